// File: doc/BRIEF.md
# Complementary Dual-Lane Swap Switch

This block steers complex samples between two processing lanes, an even lane and an odd lane, at two successive level boundaries of a twin-stream pipelined FFT. Each boundary has a four-port crossbar. Ports 1 and 2 of a crossbar carry the lower lane, and ports 3 and 4 carry the upper lane. A crossbar either keeps each sample on its own lane or exchanges the two lane pairs. Keeping a sample on its own lane moves it to the same lane at the next level. Exchanging the pairs sends it to the other lane.

A shared mode sequencer is idle until a start pulse arrives. After that it counts the cycles of each N-cycle frame and flips both crossbars together at every half-frame. The two crossbars are always in opposite modes. This lets the even and odd halves of two independent streams take turns on two half-size FFT lanes without colliding.

Every crossbar output is registered, so each output shows the inputs of the previous cycle, routed by the mode that was in force during that cycle. The mode outputs are exported so that the surrounding datapath can see which phase is active.

Top module: `dss_dual_switch`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, all eight data outputs are zero, `a_swap_o` is 1 and `b_swap_o` is 0.
- R2: In a cycle where a crossbar is in pass mode (its swap output is 0), its output port k (k = 0..3, with index 0 being port 1) shows input port k one clock later.
- R3: In a cycle where a crossbar is in swap mode (its swap output is 1), outputs 0 and 1 show inputs 2 and 3, and outputs 2 and 3 show inputs 0 and 1, one clock later.
- R4: A cycle with `start_i` high opens a frame in the next cycle. During frame cycles 1 to N/2, crossbar A is in swap mode. During frame cycles N/2+1 to N, crossbar A is in pass mode. The frames repeat back to back.
- R5: `b_swap_o` is the complement of `a_swap_o` in every cycle.
- R6: Once frames are running, both modes change exactly at each half-frame boundary and at no other time.
- R7: Until the first start pulse, the modes stay at the first-half setting (A swap, B pass) and do not toggle.
- R8: A start pulse in the middle of a frame abandons that frame, and the next cycle is frame cycle 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Frame start pulse |
| a_u_i | input | 4x2W | Crossbar A inputs; index 0..3 = ports 1..4, each a {re, im} sample |
| b_u_i | input | 4x2W | Crossbar B inputs, same layout |
| a_v_o | output | 4x2W | Crossbar A registered outputs |
| b_v_o | output | 4x2W | Crossbar B registered outputs |
| a_swap_o | output | 1 | Mode of crossbar A in the current cycle (1 = swap) |
| b_swap_o | output | 1 | Mode of crossbar B in the current cycle (1 = swap) |

## Verification
The checker checks the following on every cycle:
- The complementary modes.
- The pass and swap port maps, with one cycle of latency, for both crossbars.
- That the modes toggle only when the sequencer signals a half-frame boundary.
- That the modes stay at their first-half setting while the sequencer is idle.

The half-frame period, the start-to-first-cycle alignment and the behaviour of a restart in mid-frame can only be shown by the bench. The bench runs its own frame counter and, cycle by cycle, compares both modes and all eight tagged outputs against it through idle, running and restarted frames.

// File: rtl/dss_pkg.sv
package dss_pkg;
  localparam int unsigned PORTS = 4;
  localparam int unsigned PAIR  = 2;

  // Source input index for output k: the lane pairs exchange when swapping.
  function automatic logic [1:0] pick_src(input logic swap, input logic [1:0] k);
    logic [1:0] src;
    src = swap ? (k ^ 2'(PAIR)) : k;
    return src;
  endfunction

  // Half-frame boundary test, shared by the sequencer.
  function automatic logic at_half_edge(input int unsigned cnt, input int unsigned n);
    return (cnt == (n / 2) - 1) || (cnt == n - 1);
  endfunction
endpackage

// File: rtl/dss_mode_seq.sv
module dss_mode_seq #(
  parameter int unsigned N = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic a_swap_o,
  output logic b_swap_o,
  output logic run_o,
  output logic half_tick_o
);
  localparam int unsigned CW = (N > 2) ? $clog2(N) : 1;

  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          a_q;
  logic          b_q;
  logic          tick;

  assign tick = run_q && dss_pkg::at_half_edge(int'(cnt_q), N);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      a_q   <= 1'b1;
      b_q   <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
      a_q   <= 1'b1;
      b_q   <= 1'b0;
    end else if (run_q) begin
      cnt_q <= (int'(cnt_q) == N - 1) ? '0 : cnt_q + 1'b1;
      if (tick) begin
        a_q <= ~a_q;
        b_q <= ~b_q;
      end
    end
  end

  assign a_swap_o    = a_q;
  assign b_swap_o    = b_q;
  assign run_o       = run_q;
  assign half_tick_o = tick;
endmodule

// File: rtl/dss_xbar.sv
module dss_xbar #(
  parameter int unsigned W = 16
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    swap_i,
  input  logic [dss_pkg::PORTS-1:0][2*W-1:0]      u_i,
  output logic [dss_pkg::PORTS-1:0][2*W-1:0]      v_o
);
  for (genvar k = 0; k < dss_pkg::PORTS; k++) begin : g_port
    logic [1:0]     src;
    logic [2*W-1:0] nxt;
    always_comb begin
      src = dss_pkg::pick_src(swap_i, 2'(k));
      nxt = u_i[src];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) v_o[k] <= '0;
      else        v_o[k] <= nxt;
    end
  end
endmodule

// File: rtl/dss_dual_switch.sv
module dss_dual_switch #(
  parameter int unsigned N = 16,
  parameter int unsigned W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [3:0][2*W-1:0]    a_u_i,
  input  logic [3:0][2*W-1:0]    b_u_i,
  output logic [3:0][2*W-1:0]    a_v_o,
  output logic [3:0][2*W-1:0]    b_v_o,
  output logic                   a_swap_o,
  output logic                   b_swap_o
);
  logic seq_run;
  logic seq_tick;
  logic a_mode;
  logic b_mode;

  dss_mode_seq #(.N(N)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .a_swap_o(a_mode), .b_swap_o(b_mode),
    .run_o(seq_run), .half_tick_o(seq_tick)
  );

  dss_xbar #(.W(W)) u_xa (
    .clk(clk), .rst_n(rst_n), .swap_i(a_mode), .u_i(a_u_i), .v_o(a_v_o)
  );

  dss_xbar #(.W(W)) u_xb (
    .clk(clk), .rst_n(rst_n), .swap_i(b_mode), .u_i(b_u_i), .v_o(b_v_o)
  );

  assign a_swap_o = a_mode;
  assign b_swap_o = b_mode;
endmodule

// File: rtl/dss_dual_switch_chk.sv
module dss_dual_switch_chk #(
  parameter int unsigned W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic [3:0][2*W-1:0] a_u_i,
  input logic [3:0][2*W-1:0] b_u_i,
  input logic [3:0][2*W-1:0] a_v_o,
  input logic [3:0][2*W-1:0] b_v_o,
  input logic                a_swap_o,
  input logic                b_swap_o,
  input logic                seq_run,
  input logic                seq_tick
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R5
  modes_opposite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (a_swap_o != b_swap_o));

  // R2
  a_pass_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(a_swap_o)) |-> (a_v_o == $past(a_u_i)));

  // R2
  b_pass_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(b_swap_o)) |-> (b_v_o == $past(b_u_i)));

  // R3
  a_swap_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(a_swap_o)) |->
      (a_v_o == {$past(a_u_i[1]), $past(a_u_i[0]), $past(a_u_i[3]), $past(a_u_i[2])}));

  // R3
  b_swap_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(b_swap_o)) |->
      (b_v_o == {$past(b_u_i[1]), $past(b_u_i[0]), $past(b_u_i[3]), $past(b_u_i[2])}));

  // R6
  toggle_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(seq_tick) && !$past(start_i)) |-> (a_swap_o != $past(a_swap_o)));

  // R6
  hold_off_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(seq_tick) && !$past(start_i)) |-> $stable(a_swap_o));

  // R7
  idle_setting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(seq_run) && !$past(start_i)) |-> (a_swap_o && !b_swap_o));
endmodule

bind dss_dual_switch dss_dual_switch_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .a_u_i(a_u_i), .b_u_i(b_u_i), .a_v_o(a_v_o), .b_v_o(b_v_o),
  .a_swap_o(a_swap_o), .b_swap_o(b_swap_o),
  .seq_run(seq_run), .seq_tick(seq_tick)
);

// File: tb/dss_dual_switch_bench.sv
`timescale 1ns/1ps
module dss_dual_switch_bench;
  localparam int N = 16;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [3:0][2*W-1:0] a_u_i = '0;
  logic [3:0][2*W-1:0] b_u_i = '0;
  logic [3:0][2*W-1:0] a_v_o;
  logic [3:0][2*W-1:0] b_v_o;
  logic a_swap_o;
  logic b_swap_o;

  always #5 clk = ~clk;

  dss_dual_switch #(.N(N), .W(W)) u_dss_dual_switch (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .a_u_i(a_u_i), .b_u_i(b_u_i), .a_v_o(a_v_o), .b_v_o(b_v_o),
    .a_swap_o(a_swap_o), .b_swap_o(b_swap_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench model state
  bit m_run = 0;
  int m_idx = 0;
  bit m_prev_start = 0;
  bit m_restarted = 0;
  bit m_a = 1;
  logic [3:0][2*W-1:0] exp_a = '0;
  logic [3:0][2*W-1:0] exp_b = '0;
  int tcount = 0;

  function automatic logic [3:0][2*W-1:0] route(input logic [3:0][2*W-1:0] u, input bit sw);
    logic [3:0][2*W-1:0] r;
    for (int k = 0; k < 4; k++) r[k] = sw ? u[(k + 2) % 4] : u[k];
    return r;
  endfunction

  task automatic step(input bit st);
    @(negedge clk);
    if (m_prev_start) begin m_run = 1; m_idx = 0; end
    else if (m_run) m_idx = (m_idx + 1) % N;
    m_a = m_run ? (m_idx < N / 2) : 1'b1;
    chk(a_swap_o == m_a, m_restarted ? "R8 mode A" : (m_run ? "R4 mode A" : "R7 mode A"),
        64'(a_swap_o), 64'(m_a));
    chk(b_swap_o == !m_a, "R5 mode B", 64'(b_swap_o), 64'(!m_a));
    chk(a_v_o == exp_a, "R2 R3 R6 crossbar A data", 64'(a_v_o), 64'(exp_a));
    chk(b_v_o == exp_b, "R2 R3 R6 crossbar B data", 64'(b_v_o), 64'(exp_b));
    tcount++;
    for (int k = 0; k < 4; k++) begin
      a_u_i[k] = {4'hA, 2'(k), 10'(tcount)};
      b_u_i[k] = {4'hB, 2'(k), 10'(tcount * 3)};
    end
    start_i = st;
    exp_a = route(a_u_i, m_a);
    exp_b = route(b_u_i, !m_a);
    m_prev_start = st;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs and modes during reset
    chk(a_v_o == '0 && b_v_o == '0, "R1 data in reset", 64'(a_v_o), 64'h0);
    chk(a_swap_o == 1'b1 && b_swap_o == 1'b0, "R1 modes in reset",
        64'({a_swap_o, b_swap_o}), 64'h2);
    rst_n = 1'b1;
    // idle cycles: R7
    repeat (6) step(1'b0);
    step(1'b1);
    repeat (2 * N + N / 2 + 3) step(1'b0);
    // restart mid-frame: R8
    step(1'b1);
    m_restarted = 1;
    repeat (N / 2) step(1'b0);
    m_restarted = 0;
    repeat (2 * N) step(1'b0);
    // back-to-back start pulses
    step(1'b1);
    step(1'b1);
    repeat (N + 2) step(1'b0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule